// File: doc/BRIEF.md
# EPP Host Read Cycle Engine

This block runs one enhanced-parallel-port read transaction each time the host reads one of the two port registers: the data register or the address register. On the host side it stalls the reader by pulling a ready line low. On the peripheral side it turns the bus around, strobes the peripheral and waits for the peripheral's answer. It then captures the byte and hands it back to the host, and the host completes its read.

Every peripheral input crosses into the block's clock through a two-flop synchronizer. A wait line, active low, carries the handshake. Low means the peripheral is idle and can accept a strobe. High means the peripheral has put valid data on the bus. The block strobes only after it has seen the peripheral idle. It presents the captured byte to the host only after it has withdrawn its strobe. The peripheral-side output drivers (their enable, the direction line and the write line) return to the outbound setting only after the peripheral has lowered wait again.

A watchdog counts clock cycles while a transaction is in flight. The limit comes from an input, and about 500 cycles at 50 MHz gives roughly 10 us. When the count runs out, the block abandons the transaction, frees the host and sets a sticky timeout flag. The host interface is a plain synchronous register-read bus with no valid/ready pair. The back-pressure toward the host is the ready line alone: the host must keep its read strobe asserted while `host_rdy` is low.

Top module: `epp_rd_engine`

## Requirements
- R1: While reset is held and right after it: `host_rdy`=1, `p_dstb_n`=`p_astb_n`=1, `p_oe`=1, `p_dir`=0, `p_write_n`=0, `host_dout`=0 and `tmo_flag`=0.
- R2: When idle, `host_rdy` goes to 0 in the same cycle that `host_sel`=1 and `host_rd_n`=0 are first presented.
- R3: No strobe is asserted while the synchronized `p_wait_n` is 1. Once it reads 0, the strobe follows.
- R4: Whenever a strobe is low, `p_oe`=0, `p_dir`=1 and `p_write_n`=1. These values were already in place in the cycle before the strobe fell.
- R5: `host_sel_addr`=1 selects the address strobe `p_astb_n` and `host_sel_addr`=0 selects the data strobe `p_dstb_n`. The two strobes are never low together.
- R6: When `p_wait_n` rises while strobed, the strobe stays low for two more clock edges and rises on the third. On that same edge the byte on `p_din` is captured, `host_rdy` goes to 1 and `host_dout` shows the byte.
- R7: `host_dout` is 0 except in the hold phase that follows a capture. While a strobe is low, `host_rdy` is 0 and `host_dout` is 0.
- R8: After a capture, `p_dir`, `p_oe` and `p_write_n` keep their inbound values until `p_wait_n` is seen low again. They return to 0, 1 and 0 on the third clock edge after `p_wait_n` falls.
- R9: One host access produces at most one peripheral strobe. No new transaction starts until the host strobe or select has been released.
- R10: If a transaction is still in flight `wd_limit` cycles after it started, the block abandons it on that edge. `host_rdy` returns to 1 and both strobes return to 1.
- R11: `tmo_flag` is set by an abort only. Once set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wd_limit | input | WDW (16) | Watchdog limit in clock cycles |
| host_sel | input | 1 | Host addresses one of the two port registers |
| host_sel_addr | input | 1 | 1 = address register, 0 = data register |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_rdy | output | 1 | Host ready; low stalls the host |
| host_dout | output | DW (8) | Byte returned to the host |
| p_din | input | DW (8) | Peripheral data bus, inbound |
| p_oe | output | 1 | Enable for the block's outbound drivers on the peripheral bus |
| p_dir | output | 1 | Bus direction, 1 = inbound |
| p_write_n | output | 1 | Write-direction line, active low |
| p_dstb_n | output | 1 | Data strobe, active low |
| p_astb_n | output | 1 | Address strobe, active low |
| p_wait_n | input | 1 | Peripheral wait: 0 = idle, 1 = data valid |
| tmo_flag | output | 1 | Sticky watchdog timeout flag |

## Verification
Some properties hold on every cycle, and the assertions check those:
- the two strobes are mutually exclusive;
- the bus is released and turned inbound whenever a strobe is low, and the direction was set a cycle before the strobe fell;
- the host is stalled and the returned byte is zero while strobing;
- the timeout flag never clears.

Other behaviour depends on sequences of stimulus, and only the bench scenarios can show it. That covers the exact synchronizer latency from a wait edge to the capture, the correct byte and strobe under random data, register choice and response delays, and the late return of the direction lines. It also covers the refusal to restart while the host still holds its strobe, and the abort after exactly `wd_limit` cycles whether the peripheral stays busy or never answers.

// File: rtl/epp_rd_pkg.sv
package epp_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_STB  = 2'd2,
    ST_HOLD = 2'd3
  } rd_state_e;
endpackage

// File: rtl/epp_rd_sync.sv
module epp_rd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/epp_rd_wdog.sv
module epp_rd_wdog #(
  parameter int WDW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [WDW-1:0] limit,
  output logic           expire
);
  localparam int CW = WDW + 1;

  logic [WDW-1:0] cnt;
  logic [CW-1:0]  cnt_nxt;

  assign cnt_nxt = {1'b0, cnt} + CW'(1);
  assign expire  = run && (cnt_nxt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt <= '0;
    else if (!run || expire)  cnt <= '0;
    else                      cnt <= cnt_nxt[WDW-1:0];
endmodule

// File: rtl/epp_rd_fsm.sv
module epp_rd_fsm
  import epp_rd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_act,
  input  logic          host_sel_addr,
  input  logic          wait_s,
  input  logic [DW-1:0] data_s,
  input  logic          expire,
  output logic          wd_run,
  output logic          host_rdy,
  output logic [DW-1:0] host_dout,
  output logic          p_oe,
  output logic          p_dir,
  output logic          p_write_n,
  output logic          p_dstb_n,
  output logic          p_astb_n,
  output logic          tmo_flag
);
  rd_state_e     state;
  logic          act_q;
  logic          start;
  logic          addr_q;
  logic          rd_cfg;
  logic [DW-1:0] data_q;

  // a new access is only a fresh assertion of the host strobe
  assign start  = (state == ST_IDLE) && host_act && !act_q;
  assign wd_run = (state == ST_ARM) || (state == ST_STB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      act_q    <= 1'b0;
      addr_q   <= 1'b0;
      data_q   <= '0;
      tmo_flag <= 1'b0;
    end else begin
      act_q <= host_act;
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_ARM;
          addr_q <= host_sel_addr;
        end
        ST_ARM: begin
          if (expire) begin
            state    <= ST_IDLE;
            tmo_flag <= 1'b1;
          end else if (!wait_s) begin
            state <= ST_STB;
          end
        end
        ST_STB: begin
          if (expire) begin
            state    <= ST_IDLE;
            tmo_flag <= 1'b1;
          end else if (wait_s) begin
            state  <= ST_HOLD;
            data_q <= data_s;
          end
        end
        ST_HOLD: if (!host_act) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // inbound bus setting: taken at start, dropped once the peripheral is idle again
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      rd_cfg <= 1'b0;
    else if (start)
      rd_cfg <= 1'b1;
    else if ((state == ST_IDLE || state == ST_HOLD) && !wait_s)
      rd_cfg <= 1'b0;

  assign p_oe      = !rd_cfg;
  assign p_dir     = rd_cfg;
  assign p_write_n = rd_cfg;

  assign p_dstb_n  = !((state == ST_STB) && !addr_q);
  assign p_astb_n  = !((state == ST_STB) &&  addr_q);

  assign host_rdy  = ((state == ST_IDLE) && !start) || (state == ST_HOLD);
  assign host_dout = (state == ST_HOLD) ? data_q : '0;
endmodule

// File: rtl/epp_rd_engine.sv
module epp_rd_engine #(
  parameter int DW  = 8,
  parameter int WDW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WDW-1:0] wd_limit,
  input  logic           host_sel,
  input  logic           host_sel_addr,
  input  logic           host_rd_n,
  output logic           host_rdy,
  output logic [DW-1:0]  host_dout,
  input  logic [DW-1:0]  p_din,
  output logic           p_oe,
  output logic           p_dir,
  output logic           p_write_n,
  output logic           p_dstb_n,
  output logic           p_astb_n,
  input  logic           p_wait_n,
  output logic           tmo_flag
);
  localparam int SW = DW + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {DW{1'b0}}};

  logic [SW-1:0] sync_q;
  logic          wait_s;
  logic [DW-1:0] data_s;
  logic          wd_run;
  logic          expire;
  logic          host_act;

  assign host_act = host_sel && !host_rd_n;

  epp_rd_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({p_wait_n, p_din}),
    .q     (sync_q)
  );

  assign wait_s = sync_q[DW];
  assign data_s = sync_q[DW-1:0];

  epp_rd_wdog #(.WDW(WDW)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wd_run),
    .limit  (wd_limit),
    .expire (expire)
  );

  epp_rd_fsm #(.DW(DW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_act      (host_act),
    .host_sel_addr (host_sel_addr),
    .wait_s        (wait_s),
    .data_s        (data_s),
    .expire        (expire),
    .wd_run        (wd_run),
    .host_rdy      (host_rdy),
    .host_dout     (host_dout),
    .p_oe          (p_oe),
    .p_dir         (p_dir),
    .p_write_n     (p_write_n),
    .p_dstb_n      (p_dstb_n),
    .p_astb_n      (p_astb_n),
    .tmo_flag      (tmo_flag)
  );
endmodule

// File: rtl/epp_rd_chk.sv
module epp_rd_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rdy,
  input logic [DW-1:0] host_dout,
  input logic          p_oe,
  input logic          p_dir,
  input logic          p_write_n,
  input logic          p_dstb_n,
  input logic          p_astb_n,
  input logic          tmo_flag
);
  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!p_dstb_n && !p_astb_n));

  // R4
  bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_dstb_n || !p_astb_n) |-> (!p_oe && p_dir && p_write_n));

  // R4
  dir_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(p_dstb_n) || $fell(p_astb_n)) |-> $past(p_dir));

  // R7
  stall_while_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_dstb_n || !p_astb_n) |-> (!host_rdy && host_dout == '0));

  // R7
  quiet_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdy |-> (host_dout == '0));

  // R11
  sticky_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |=> tmo_flag);
endmodule

bind epp_rd_engine epp_rd_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_rdy  (host_rdy),
  .host_dout (host_dout),
  .p_oe      (p_oe),
  .p_dir     (p_dir),
  .p_write_n (p_write_n),
  .p_dstb_n  (p_dstb_n),
  .p_astb_n  (p_astb_n),
  .tmo_flag  (tmo_flag)
);

// File: tb/sim_epp_rd_engine.sv
`timescale 1ns/1ps
module sim_epp_rd_engine;
  localparam int DW  = 8;
  localparam int WDW = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [WDW-1:0] wd_limit = 16'd64;
  logic           host_sel = 1'b0;
  logic           host_sel_addr = 1'b0;
  logic           host_rd_n = 1'b1;
  logic           host_rdy;
  logic [DW-1:0]  host_dout;
  logic [DW-1:0]  p_din = '0;
  logic           p_oe, p_dir, p_write_n, p_dstb_n, p_astb_n;
  logic           p_wait_n = 1'b0;
  logic           tmo_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  epp_rd_engine #(.DW(DW), .WDW(WDW)) u0 (
    .clk(clk), .rst_n(rst_n), .wd_limit(wd_limit),
    .host_sel(host_sel), .host_sel_addr(host_sel_addr), .host_rd_n(host_rd_n),
    .host_rdy(host_rdy), .host_dout(host_dout), .p_din(p_din),
    .p_oe(p_oe), .p_dir(p_dir), .p_write_n(p_write_n),
    .p_dstb_n(p_dstb_n), .p_astb_n(p_astb_n), .p_wait_n(p_wait_n),
    .tmo_flag(tmo_flag)
  );

  // expected strobe pair {astb_n, dstb_n} while strobing
  function automatic logic [1:0] exp_stb(input logic addr);
    return addr ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    host_sel = 1'b0; host_rd_n = 1'b1; p_wait_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset values
    chk(host_rdy && p_dstb_n && p_astb_n && p_oe && !p_dir && !p_write_n &&
        host_dout == 0 && !tmo_flag, "R1 reset state",
        {host_rdy, p_dstb_n, p_astb_n, p_oe, p_dir, p_write_n, tmo_flag}, 7'b1111000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_start(input logic addr);
    host_sel = 1'b1; host_sel_addr = addr; host_rd_n = 1'b0;
    #1;
    // R2 immediate stall
    chk(!host_rdy, "R2 host stalled at once", host_rdy, 0);
  endtask

  task automatic do_read(input logic addr, input logic [7:0] data,
                         input bit pre_busy, input int dly);
    bit seen = 1'b0;
    if (pre_busy) begin
      p_wait_n = 1'b1;
      repeat (3) @(negedge clk);
    end
    p_din = ~data;
    host_start(addr);
    if (pre_busy) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        // R3 no strobe while peripheral busy
        chk(p_dstb_n && p_astb_n, "R3 no strobe while busy", {p_astb_n, p_dstb_n}, 2'b11);
      end
      p_wait_n = 1'b0;
    end
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (!p_dstb_n || !p_astb_n) seen = 1'b1;
    end
    chk(seen, "R3 strobe follows idle wait", seen, 1);
    // R5 strobe choice
    chk({p_astb_n, p_dstb_n} == exp_stb(addr), "R5 strobe select",
        {p_astb_n, p_dstb_n}, exp_stb(addr));
    // R4 bus released and inbound
    chk(!p_oe && p_dir && p_write_n, "R4 bus inbound while strobing",
        {p_oe, p_dir, p_write_n}, 3'b011);
    // R7 host held off, no data shown
    chk(!host_rdy && host_dout == 0, "R7 no data while strobing", host_dout, 0);
    p_din = data;
    repeat (dly) @(negedge clk);
    p_wait_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R6 strobe still low during synchronizer latency
    chk({p_astb_n, p_dstb_n} == exp_stb(addr), "R6 strobe held for sync",
        {p_astb_n, p_dstb_n}, exp_stb(addr));
    @(posedge clk); #1;
    // R6 capture on third edge
    chk(p_dstb_n && p_astb_n && host_rdy && host_dout == data, "R6 capture and release",
        host_dout, data);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R9 host still holding: no second strobe
      chk(p_dstb_n && p_astb_n && host_rdy, "R9 single strobe per access",
          {p_astb_n, p_dstb_n}, 2'b11);
      // R8 direction kept while wait high
      chk(p_dir && !p_oe, "R8 direction kept until wait low", p_dir, 1);
    end
    host_sel = 1'b0; host_rd_n = 1'b1; p_wait_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(p_dir, "R8 direction held during sync", p_dir, 1);
    // R7 data removed once host done
    chk(host_dout == 0, "R7 dout cleared after access", host_dout, 0);
    @(posedge clk); #1;
    chk(!p_dir && p_oe && !p_write_n, "R8 direction restored",
        {p_oe, p_dir, p_write_n}, 3'b100);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_0042);
    do_reset();

    // directed corners
    do_read(1'b0, 8'hA5, 1'b0, 0);
    do_read(1'b1, 8'h3C, 1'b1, 4);
    do_read(1'b1, 8'h00, 1'b0, 9);
    do_read(1'b0, 8'hFF, 1'b1, 1);

    // random mix
    for (int n = 0; n < 30; n++) begin
      do_read(1'($urandom), 8'($urandom), 1'($urandom), int'($urandom % 9));
    end
    // R11 completed reads never set the flag
    chk(!tmo_flag, "R11 no flag after good reads", tmo_flag, 0);

    // R10 abort while strobing: peripheral never answers
    wd_limit = 16'd20;
    host_start(1'b0);
    for (int i = 0; i < 40 && host_rdy == 1'b0; i++) @(negedge clk);
    chk(host_rdy && p_dstb_n && p_astb_n && tmo_flag, "R10 abort during strobe",
        {host_rdy, p_dstb_n, p_astb_n, tmo_flag}, 4'hF);
    host_sel = 1'b0; host_rd_n = 1'b1;
    repeat (5) @(negedge clk);
    // R11 flag sticky
    chk(tmo_flag, "R11 flag sticky", tmo_flag, 1);

    // R10 exact window with peripheral busy from the start
    do_reset();
    wd_limit = 16'd20;
    p_wait_n = 1'b1;
    repeat (3) @(negedge clk);
    host_start(1'b1);
    @(posedge clk);
    repeat (19) @(posedge clk);
    #1;
    chk(!host_rdy && !tmo_flag, "R10 still waiting before limit", {host_rdy, tmo_flag}, 0);
    @(posedge clk); #1;
    chk(host_rdy && tmo_flag && p_dstb_n && p_astb_n, "R10 abort at limit",
        {host_rdy, tmo_flag}, 2'b11);
    p_wait_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      // R9 held host strobe does not restart
      chk(p_dstb_n && p_astb_n && host_rdy, "R9 no restart after abort",
          {p_astb_n, p_dstb_n}, 2'b11);
    end
    host_sel = 1'b0; host_rd_n = 1'b1;
    repeat (3) @(negedge clk);
    wd_limit = 16'd64;
    do_read(1'b0, 8'h5A, 1'b0, 2);
    chk(tmo_flag, "R11 flag survives later reads", tmo_flag, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule